// File: doc/BRIEF.md
# MDIO Management Master

This block is the master end of a two-wire station-management bus, the kind used to read and write registers in an Ethernet PHY. A host presents one request at a time through a valid/ready handshake. The request carries a read/write flag, a 5-bit PHY address, a 5-bit register address and, for writes, 16 bits of data. The block then runs one complete frame on the serial clock and data lines and ends it with a one-clock `done` pulse.

The serial clock is made from the system clock by a half-period counter. The counter's period is a runtime input, so the bus rate is independent of the system clock. The data line is driven through a separate output and output-enable, and the enable is dropped whenever the PHY owns the line. The input side passes through a two-flop synchronizer before any bit is taken from it.

On a read, the block checks the turnaround bit. If no PHY pulls it low, the block clocks 32 recovery cycles with the line released and reports an error instead of data.

Top module: `mdio_master`

## Requirements
- R1: After reset, `mdc` is 0, `mdio_oe` is 0, `req_ready` is 1, `done` is 0, and `rd_err` and `rd_data` are 0.
- R2: Every frame opens with 32 serial-clock cycles in which `mdio_oe`=1 and `mdio_o`=1.
- R3: Frame cycles 32..45 carry the following bits in this order: 0,1; then the operation code (1,0 for a read, 0,1 for a write); then the PHY address MSB first; then the register address MSB first.
- R4: Each serial-clock cycle is a low phase followed by a high phase. Each phase lasts `half_period` system clocks, and a value of 0 counts as 1. `half_period` and the request fields are captured when the request is accepted. Driven bits change only at the start of a low phase. A frame of N cycles runs for 2·N·half_period clocks from acceptance to `done`.
- R5: A write drives the turnaround bits 1,0 in cycles 46..47 and the data MSB first in cycles 48..63. Cycle 64 then runs with `mdio_oe`=0, for 65 cycles in all.
- R6: A read sets `mdio_oe`=0 from cycle 46 onward. It samples the turnaround bit at the end of the high phase of cycle 46. It takes 16 data bits MSB first at the ends of the high phases of cycles 47..62, then runs cycles 63..64, for 65 cycles in all.
- R7: If the sampled turnaround bit is 1, the block runs 32 more cycles with `mdio_oe`=0 (79 in all). It then sets `rd_err`=1 with `rd_data`=0.
- R8: Every frame ends with `mdc` high, and `mdc` stays high while idle. `done` is a single-clock pulse. `req_ready` is 1 only while idle, and a request presented while busy is ignored.
- R9: `rd_data` and `rd_err` hold their values until the next request is accepted, and acceptance clears both to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| half_period | input | HP_W | Serial-clock half period in system clocks (0 treated as 1) |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request will be taken |
| req_read | input | 1 | 1 = read, 0 = write |
| req_phy | input | 5 | PHY address |
| req_reg | input | 5 | Register address |
| req_wdata | input | 16 | Write data |
| mdc | output | 1 | Serial management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input (asynchronous) |
| done | output | 1 | One-clock end-of-transaction pulse |
| rd_data | output | 16 | Read result |
| rd_err | output | 1 | Turnaround not driven low by the PHY |

## Verification
The assertions check on every cycle the properties that hold at all times:
- the line is released whenever the block is idle;
- driven bits stay still through a high phase;
- `done` lasts one clock and coincides with idle and a high `mdc`;
- results stay unchanged between acceptances;
- an error never carries data.

Only the bench scenarios can show that the bit order of the preamble, header, turnaround and data is right, that the frame length and total latency match the captured half period, and that a missing turnaround leads to the 32 recovery cycles. The bench shows these by decoding the captured frame against values it computes itself.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int CYC_W = 7;

    localparam logic [CYC_W-1:0] PRE_LAST   = 7'd31;
    localparam logic [CYC_W-1:0] HDR_FIRST  = 7'd32;
    localparam logic [CYC_W-1:0] TA_CYC     = 7'd46;
    localparam logic [CYC_W-1:0] RD_FIRST   = 7'd47;
    localparam logic [CYC_W-1:0] RD_LAST    = 7'd62;
    localparam logic [CYC_W-1:0] WR_DRV_END = 7'd63;
    localparam logic [CYC_W-1:0] FRAME_LAST = 7'd64;
    localparam logic [CYC_W-1:0] RECOV_LAST = 7'd31;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } seq_state_e;

    typedef struct packed {
        seq_state_e       st;
        logic             hi;
        logic             rd;
        logic             rec;
        logic [CYC_W-1:0] cyc;
        logic [31:0]      sh;
        logic [15:0]      rdat;
        logic             err;
        logic             mdc;
        logic             mdo;
        logic             oe;
        logic             done;
    } seq_t;

endpackage

// File: rtl/mdio_phase_timer.sv
module mdio_phase_timer #(
    parameter int HP_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic [HP_W-1:0] half_period,
    output logic            tick
);
    logic [HP_W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = en && (cnt_q == half_period - HP_W'(1));
        cnt_d = (!en || tick) ? '0 : cnt_q + HP_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/mdio_in_sync.sv
module mdio_in_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] ff_d, ff_q;

    always_comb begin
        ff_d = {ff_q[STAGES-2:0], din};
        dout = ff_q[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ff_q <= '1;
        else        ff_q <= ff_d;
    end
endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_pkg::*;
#(
    parameter int HP_W        = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [HP_W-1:0] half_period,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic            req_read,
    input  logic [4:0]      req_phy,
    input  logic [4:0]      req_reg,
    input  logic [15:0]     req_wdata,
    output logic            mdc,
    output logic            mdio_o,
    output logic            mdio_oe,
    input  logic            mdio_i,
    output logic            done,
    output logic [15:0]     rd_data,
    output logic            rd_err
);
    seq_t            s_d, s_q;
    logic [HP_W-1:0] hp_d, hp_q;
    logic            tick;
    logic            mdio_s;

    mdio_phase_timer #(.HP_W(HP_W)) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .en          (s_q.st == ST_RUN),
        .half_period (hp_q),
        .tick        (tick)
    );

    mdio_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (mdio_i),
        .dout  (mdio_s)
    );

    always_comb begin
        logic             last;
        logic             fail;
        logic             rec_n;
        logic [CYC_W-1:0] nxt;

        s_d      = s_q;
        s_d.done = 1'b0;
        hp_d     = hp_q;
        last     = 1'b0;
        fail     = 1'b0;
        rec_n    = s_q.rec;
        nxt      = s_q.cyc;

        if (s_q.st == ST_IDLE) begin
            if (req_valid) begin
                // start of cycle 0: low phase with the preamble bit driven
                s_d.st   = ST_RUN;
                s_d.hi   = 1'b0;
                s_d.rd   = req_read;
                s_d.rec  = 1'b0;
                s_d.cyc  = '0;
                s_d.sh   = {2'b01,
                            req_read ? 2'b10 : 2'b01,
                            req_phy, req_reg,
                            req_read ? 2'b00 : 2'b10,
                            req_read ? 16'h0000 : req_wdata};
                s_d.rdat = '0;
                s_d.err  = 1'b0;
                s_d.mdc  = 1'b0;
                s_d.mdo  = 1'b1;
                s_d.oe   = 1'b1;
                hp_d     = (half_period == '0) ? HP_W'(1) : half_period;
            end
        end else if (tick) begin
            if (!s_q.hi) begin
                s_d.mdc = 1'b1;
                s_d.hi  = 1'b1;
            end else begin
                // end of high phase: sample point for reads
                if (s_q.rd && !s_q.rec) begin
                    if (s_q.cyc == TA_CYC && mdio_s)
                        fail = 1'b1;
                    if (s_q.cyc >= RD_FIRST && s_q.cyc <= RD_LAST)
                        s_d.rdat = {s_q.rdat[14:0], mdio_s};
                end
                last = s_q.rec ? (s_q.cyc == RECOV_LAST) : (s_q.cyc == FRAME_LAST);
                if (last) begin
                    s_d.st   = ST_IDLE;
                    s_d.done = 1'b1;
                    s_d.err  = s_q.rec;
                end else begin
                    nxt     = fail ? '0 : s_q.cyc + CYC_W'(1);
                    rec_n   = s_q.rec | fail;
                    s_d.cyc = nxt;
                    s_d.rec = rec_n;
                    s_d.hi  = 1'b0;
                    s_d.mdc = 1'b0;
                    if (rec_n) begin
                        s_d.oe  = 1'b0;
                        s_d.mdo = 1'b0;
                    end else if (nxt <= PRE_LAST) begin
                        s_d.oe  = 1'b1;
                        s_d.mdo = 1'b1;
                    end else if (( s_q.rd && nxt < TA_CYC) ||
                                 (!s_q.rd && nxt <= WR_DRV_END)) begin
                        s_d.oe  = 1'b1;
                        s_d.mdo = s_q.sh[31];
                        s_d.sh  = {s_q.sh[30:0], 1'b0};
                    end else begin
                        s_d.oe  = 1'b0;
                        s_d.mdo = 1'b0;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q  <= '0;
            hp_q <= HP_W'(1);
        end else begin
            s_q  <= s_d;
            hp_q <= hp_d;
        end
    end

    assign req_ready = (s_q.st == ST_IDLE);
    assign mdc       = s_q.mdc;
    assign mdio_o    = s_q.mdo;
    assign mdio_oe   = s_q.oe;
    assign done      = s_q.done;
    assign rd_data   = s_q.rdat;
    assign rd_err    = s_q.err;
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic        mdc,
    input logic        mdio_o,
    input logic        mdio_oe,
    input logic        done,
    input logic [15:0] rd_data,
    input logic        rd_err
);
    a_r1_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !mdio_oe);

    a_r4_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
        (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));

    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r8_done_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (req_ready && mdc));

    a_r9_results_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && !req_valid) |=> ($stable(rd_data) && $stable(rd_err)));

    a_r7_err_no_data: assert property (@(posedge clk) disable iff (!rst_n)
        rd_err |-> (rd_data == 16'h0000));
endmodule

bind mdio_master mdio_master_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .mdc       (mdc),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe),
    .done      (done),
    .rd_data   (rd_data),
    .rd_err    (rd_err)
);

// File: tb/sim_mdio_master.sv
module sim_mdio_master;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  half_period = 8'd2;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_read = 1'b0;
    logic [4:0]  req_phy = '0;
    logic [4:0]  req_reg = '0;
    logic [15:0] req_wdata = '0;
    logic        mdc, mdio_o, mdio_oe, done, rd_err;
    logic        mdio_i = 1'b1;
    logic [15:0] rd_data;

    always #4 clk = ~clk;

    mdio_master u0 (
        .clk(clk), .rst_n(rst_n), .half_period(half_period),
        .req_valid(req_valid), .req_ready(req_ready), .req_read(req_read),
        .req_phy(req_phy), .req_reg(req_reg), .req_wdata(req_wdata),
        .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i),
        .done(done), .rd_data(rd_data), .rd_err(rd_err)
    );

    int n_chk = 0;
    int n_fail = 0;

    task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    // PHY model and frame capture
    bit        cur_rd = 0;
    bit        phy_ta = 0;
    logic [15:0] phy_data = '0;
    int        cur_hp = 2;
    int        rises = 0;
    int        ntog = 0;
    int        bad_hp = 0;
    int        last_t = 0;
    int        clk_n = 0;
    logic      mdc_prev = 1'b0;
    bit        cap_oe [128];
    bit        cap_do [128];

    always @(negedge clk) begin
        if (mdc && !mdc_prev) begin
            if (rises < 128) begin
                cap_oe[rises] = mdio_oe;
                cap_do[rises] = mdio_o;
            end
            rises++;
        end
        if (!mdc && mdc_prev) begin
            if (cur_rd && rises == 46)
                mdio_i = phy_ta;
            else if (cur_rd && !phy_ta && rises >= 47 && rises <= 62)
                mdio_i = phy_data[62-rises];
            else
                mdio_i = 1'b1;
        end
        if (mdc != mdc_prev) begin
            if (ntog > 0 && (clk_n - last_t) != cur_hp) bad_hp++;
            last_t = clk_n;
            ntog++;
        end
        mdc_prev = mdc;
        clk_n++;
    end

    task automatic run_txn(input bit rd, input logic [4:0] phy, input logic [4:0] rg,
                           input logic [15:0] wd, input bit ta, input logic [15:0] pd,
                           input int hp);
        int ncyc, lat, e_pre, e_hdr, e_tail;
        logic [13:0] hdr;
        logic [17:0] tail;
        logic [15:0] exp_data;
        bit exp_err;
        cur_rd   = rd;
        phy_ta   = ta;
        phy_data = pd;
        cur_hp   = (hp == 0) ? 1 : hp;
        @(negedge clk);
        rises = 0; ntog = 0; bad_hp = 0;
        req_valid = 1'b1; req_read = rd; req_phy = phy; req_reg = rg;
        req_wdata = wd; half_period = 8'(hp);
        @(negedge clk);
        // scramble inputs: captured values must be used
        req_valid = 1'b0; req_read = ~rd; req_phy = ~phy; req_reg = ~rg;
        req_wdata = ~wd; half_period = 8'(hp + 3);
        lat = 0;
        while (!done && lat < 4000) begin
            @(negedge clk);
            lat++;
            if (lat == 1) begin
                chk(rd_err == 1'b0, "R9 err cleared on accept", longint'(rd_err), 0);
                chk(rd_data == 16'h0, "R9 data cleared on accept", longint'(rd_data), 0);
            end
            if (lat == 3) begin
                chk(req_ready == 1'b0, "R8 not ready while busy", longint'(req_ready), 0);
                req_valid = 1'b1;   // must be ignored while busy
            end
            if (lat == 13) req_valid = 1'b0;
        end
        exp_err  = rd && ta;
        ncyc     = exp_err ? 79 : 65;
        exp_data = (rd && !ta) ? pd : 16'h0;
        chk(lat == 2 * cur_hp * ncyc, "R4 frame latency", lat, 2 * cur_hp * ncyc);
        chk(bad_hp == 0, "R4 phase length", bad_hp, 0);
        chk(rises == ncyc, rd ? (ta ? "R7 cycle count" : "R6 cycle count") : "R5 cycle count",
            rises, ncyc);
        e_pre = 0;
        for (int k = 0; k < 32; k++) if (!(cap_oe[k] && cap_do[k])) e_pre++;
        chk(e_pre == 0, "R2 preamble", e_pre, 0);
        hdr = {2'b01, rd ? 2'b10 : 2'b01, phy, rg};
        e_hdr = 0;
        for (int k = 32; k < 46; k++) if (!cap_oe[k] || cap_do[k] != hdr[45-k]) e_hdr++;
        chk(e_hdr == 0, "R3 header bits", e_hdr, 0);
        e_tail = 0;
        if (!rd) begin
            tail = {2'b10, wd};
            for (int k = 46; k < 64; k++) if (!cap_oe[k] || cap_do[k] != tail[63-k]) e_tail++;
            if (cap_oe[64]) e_tail++;
            chk(e_tail == 0, "R5 write turnaround/data/release", e_tail, 0);
        end else begin
            for (int k = 46; k < ncyc && k < 128; k++) if (cap_oe[k]) e_tail++;
            chk(e_tail == 0, ta ? "R7 released during recovery" : "R6 released from turnaround",
                e_tail, 0);
        end
        chk(rd_data == exp_data, rd ? "R6 read data" : "R5 no read data on write",
            longint'(rd_data), longint'(exp_data));
        chk(rd_err == exp_err, "R7 error flag", longint'(rd_err), longint'(exp_err));
        chk(mdc == 1'b1 && req_ready == 1'b1, "R8 mdc high and ready at end",
            longint'({mdc, req_ready}), 3);
        @(negedge clk);
        chk(done == 1'b0, "R8 done single clock", longint'(done), 0);
        repeat (4) @(negedge clk);
        chk(rd_data == exp_data && rd_err == exp_err && mdc == 1'b1, "R9 results held",
            longint'({rd_err, rd_data}), longint'({exp_err, exp_data}));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(mdc == 0 && mdio_oe == 0 && req_ready == 1 && done == 0, "R1 reset outputs",
            longint'({mdc, mdio_oe, req_ready, done}), 2);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(rd_err == 0 && rd_data == 0 && mdc == 0 && mdio_oe == 0, "R1 after reset release",
            longint'({rd_err, rd_data}), 0);
        foreach (cap_oe[k]) begin cap_oe[k] = 0; cap_do[k] = 0; end
        for (int h = 0; h < 3; h++) begin
            int hp;
            hp = (h == 0) ? 2 : (h == 1) ? 3 : 5;
            for (int i = 0; i < 4; i++) begin
                run_txn(1'b0, 5'((i * 11) % 32), 5'(31 - i * 10),
                        16'(16'hFFFF >> (i * 5)) ^ 16'(i * 16'h1234), 1'b0, 16'h0, hp);
                run_txn(1'b1, 5'((i * 7 + h) % 32), 5'(i * 10),
                        16'h0, 1'b0, 16'(16'h8001 << i) ^ 16'(i * 16'h0F0F), hp);
            end
            run_txn(1'b1, 5'(h + 3), 5'(h * 5), 16'h0, 1'b1, 16'hBEEF, hp);
        end
        run_txn(1'b0, 5'd31, 5'd0, 16'h8000, 1'b0, 16'h0, 0);  // R4 zero treated as one
        run_txn(1'b1, 5'd0, 5'd31, 16'h0, 1'b0, 16'hFFFF, 2);
        run_txn(1'b1, 5'd16, 5'd1, 16'h0, 1'b0, 16'h0000, 2);
        summary();
        $finish;
    end
endmodule